// File: doc/BRIEF.md
# Three-wire serial EEPROM shift engine

This block is a serial master for a three-wire EEPROM link. It has one serial clock output and one data line, which is split at the block edge into a driven value, an output enable and a sampled input. Software writes an 8-bit data register and then a control byte. Each accepted control write starts one burst of 0 to 8 clocks. The burst either shifts the data register out, most significant bit first, or shifts line samples into it. Chip select is a separate general-purpose output. Building EEPROM commands out of bursts is left to software.

The control byte carries a clock count, a read flag, a float flag and a wait-for-ready flag. The float flag releases the data line right after the last rising clock edge, so that the EEPROM can take it over. With float set, wait-for-ready holds busy after the burst until the EEPROM pulls the line high, which marks the end of its internal write. A one-cycle interrupt pulse follows every falling edge of busy. The serial clock is the system clock divided by `2*HALF_CYCLES`. Data changes on the falling edge and is sampled on the rising edge.

Top module: `eeprom3w_engine`

## Requirements
- R1: A control write (`ctrl_wr`=1) while busy is low is accepted, and busy is high from the next cycle. A control write while busy is high is ignored: the control readback and the running burst are unchanged.
- R2: Control byte layout: bit 7 is wait-for-ready, bit 6 is busy (read only), bit 5 is float, bit 4 is read and bits 3:0 are the count. The count field is clamped to 8 when written above 8. `ctrl_rdata` returns the latched flags, the clamped count and the live busy bit.
- R3: `sck` is low whenever the block is idle. A burst with count N gives exactly N clock periods, each `HALF_CYCLES` system cycles low and then `HALF_CYCLES` high. The first low half starts in the cycle after the accepting write.
- R4: With read clear and count N>0, `sd_oe` is 1 and `sd_out` carries bit 7, then bit 6, and so on of the data register. Each bit appears at the start of its low half and holds through its high half. After the burst the data register equals its old value shifted left by N, with zeros filled in.
- R5: With read set, `sd_oe` is 0 throughout the burst. `sd_in` is sampled in the cycle that `sck` rises. After the burst the data register equals (old value << N) with the N samples in the low N bits, the first sample being the most significant of them.
- R6: With float set and count N>0, `sd_oe` goes to 0 in the same cycle as the last rising edge of `sck` and stays 0 after the burst.
- R7: With count 0, no clock is issued. One cycle after acceptance the line follows the float flag: it is driven to 0 if float is clear and released if float is set.
- R8: Busy stays high through the last high half and one further cycle with `sck` low, then falls. At the cycle busy falls with float clear, `sd_oe`=1 and `sd_out`=0.
- R9: `irq` is high for exactly one cycle: the first cycle in which busy is low after having been high.
- R10: With wait-for-ready and float both set, busy stays high after the burst until `sd_in` is seen rising (0 in one cycle, 1 in the next). It falls one cycle after that rise. With float clear, wait-for-ready has no effect on timing.
- R11: A data write (`data_wr`=1) while busy is high, or in the same cycle as an accepted control write, is ignored. While idle with no write the data register holds.
- R12: After reset `sck`=0, `sd_oe`=0, `sd_out`=0, busy=0, `irq`=0, `ctrl_rdata`=0 and `data_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ctrl_wr | input | 1 | Control byte write strobe |
| ctrl_wdata | input | CNT_W+4 | Control byte written |
| data_wr | input | 1 | Data register write strobe |
| data_wdata | input | DATA_W | Data register value written |
| ctrl_rdata | output | CNT_W+4 | Latched control with live busy bit |
| data_rdata | output | DATA_W | Data register contents |
| busy | output | 1 | Burst or ready-wait in progress |
| irq | output | 1 | One-cycle pulse when busy falls |
| sck | output | 1 | Serial clock |
| sd_out | output | 1 | Data line drive value |
| sd_oe | output | 1 | Data line drive enable |
| sd_in | input | 1 | Data line sampled value |

## Verification
The checker watches, on every cycle, the relations that need no knowledge of the burst pattern. It checks that busy follows an accepted write, that the configuration stays frozen while busy, that the clock stays low and quiet when idle, that the line is released during reads, that the interrupt pulse lines up with the fall of busy, and that the data register holds while idle. The exact bit order on the line, the right-justified read result, the cycle at which the line floats, the clamp of the count and the wait for the EEPROM's ready edge depend on data and count values. Only the bench scenarios show these, by comparing against a cycle-by-cycle model of the expected waveform.

// File: rtl/eeprom3w_pkg.sv
package eeprom3w_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOW,
      ST_HIGH,
      ST_FIN,
      ST_WAIT
   } seq_state_e;

endpackage

// File: rtl/eeprom3w_tick.sv
module eeprom3w_tick #(
   parameter int HALF_CYCLES = 250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int PW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
   localparam logic [PW-1:0] LAST = PW'(HALF_CYCLES - 1);

   logic [PW-1:0] phase_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_cnt <= '0;
      end else if (!run || phase_cnt == LAST) begin
         phase_cnt <= '0;
      end else begin
         phase_cnt <= phase_cnt + 1'b1;
      end
   end

   assign tick = run && (phase_cnt == LAST);
endmodule

// File: rtl/eeprom3w_shreg.sv
module eeprom3w_shreg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              shift,
   input  logic              fill,
   output logic [DATA_W-1:0] data,
   output logic              msb
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data <= '0;
      end else if (load) begin
         data <= load_data;
      end else if (shift) begin
         data <= {data[DATA_W-2:0], fill};
      end
   end

   assign msb = data[DATA_W-1];
endmodule

// File: rtl/eeprom3w_seq.sv
module eeprom3w_seq
   import eeprom3w_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] wr_cnt,
   input  logic             wr_rd,
   input  logic             cfg_rd,
   input  logic             cfg_hiz,
   input  logic             cfg_wfr,
   input  logic             tick,
   input  logic             msb,
   input  logic             sd_in,
   output logic             run,
   output logic             shift,
   output logic             fill,
   output logic             sck,
   output logic             sd_out,
   output logic             sd_oe,
   output logic             busy,
   output logic             irq
);
   seq_state_e       state;
   logic [CNT_W-1:0] bits_left;
   logic             sd_prev;
   logic             sd_rise;

   assign sd_rise = sd_in && !sd_prev;
   assign run     = (state == ST_LOW) || (state == ST_HIGH);

   always_comb begin
      shift = 1'b0;
      fill  = 1'b0;
      if (state == ST_IDLE && start && wr_cnt != '0 && !wr_rd) begin
         shift = 1'b1;
      end
      if (state == ST_LOW && tick && cfg_rd) begin
         shift = 1'b1;
         fill  = sd_in;
      end
      if (state == ST_HIGH && tick && bits_left != '0 && !cfg_rd) begin
         shift = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bits_left <= '0;
         sck       <= 1'b0;
         sd_out    <= 1'b0;
         sd_oe     <= 1'b0;
         busy      <= 1'b0;
         irq       <= 1'b0;
         sd_prev   <= 1'b0;
      end else begin
         sd_prev <= sd_in;
         irq     <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  busy      <= 1'b1;
                  bits_left <= wr_cnt;
                  if (wr_cnt == '0) begin
                     state <= ST_FIN;
                  end else begin
                     state <= ST_LOW;
                     sd_oe <= !wr_rd;
                     if (!wr_rd) begin
                        sd_out <= msb;
                     end
                  end
               end
            end
            ST_LOW: begin
               if (tick) begin
                  sck       <= 1'b1;
                  bits_left <= bits_left - 1'b1;
                  state     <= ST_HIGH;
                  if (bits_left == CNT_W'(1) && cfg_hiz) begin
                     sd_oe <= 1'b0;
                  end
               end
            end
            ST_HIGH: begin
               if (tick) begin
                  sck <= 1'b0;
                  if (bits_left == '0) begin
                     state <= ST_FIN;
                  end else begin
                     state <= ST_LOW;
                     if (!cfg_rd) begin
                        sd_out <= msb;
                     end
                  end
               end
            end
            ST_FIN: begin
               if (cfg_hiz) begin
                  sd_oe <= 1'b0;
               end else begin
                  sd_oe  <= 1'b1;
                  sd_out <= 1'b0;
               end
               if (cfg_hiz && cfg_wfr) begin
                  state <= ST_WAIT;
               end else begin
                  state <= ST_IDLE;
                  busy  <= 1'b0;
                  irq   <= 1'b1;
               end
            end
            ST_WAIT: begin
               if (sd_rise) begin
                  state <= ST_IDLE;
                  busy  <= 1'b0;
                  irq   <= 1'b1;
               end
            end
            default: begin
               state <= ST_IDLE;
               busy  <= 1'b0;
            end
         endcase
      end
   end
endmodule

// File: rtl/eeprom3w_engine.sv
module eeprom3w_engine #(
   parameter int DATA_W      = 8,
   parameter int CNT_W       = 4,
   parameter int HALF_CYCLES = 250,
   localparam int CTRL_W     = CNT_W + 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   input  logic              data_wr,
   input  logic [DATA_W-1:0] data_wdata,
   output logic [CTRL_W-1:0] ctrl_rdata,
   output logic [DATA_W-1:0] data_rdata,
   output logic              busy,
   output logic              irq,
   output logic              sck,
   output logic              sd_out,
   output logic              sd_oe,
   input  logic              sd_in
);
   localparam int BIT_RD  = CNT_W;
   localparam int BIT_HIZ = CNT_W + 1;
   localparam int BIT_WFR = CNT_W + 3;
   localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(DATA_W);

   generate
      if (HALF_CYCLES < 1) begin : g_bad_half
         $error("HALF_CYCLES must be at least 1");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("DATA_W must be at least 2");
      end
      if ((1 << CNT_W) <= DATA_W) begin : g_bad_cnt
         $error("CNT_W too narrow to hold DATA_W");
      end
   endgenerate

   logic             accept;
   logic [CNT_W-1:0] raw_cnt;
   logic [CNT_W-1:0] wr_cnt;
   logic             cfg_rd, cfg_hiz, cfg_wfr;
   logic [CNT_W-1:0] cfg_cnt;
   logic             tick, run, shift, fill, msb;

   assign accept  = ctrl_wr && !busy;
   assign raw_cnt = ctrl_wdata[CNT_W-1:0];
   assign wr_cnt  = (raw_cnt > MAX_CNT) ? MAX_CNT : raw_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_rd  <= 1'b0;
         cfg_hiz <= 1'b0;
         cfg_wfr <= 1'b0;
         cfg_cnt <= '0;
      end else if (accept) begin
         cfg_rd  <= ctrl_wdata[BIT_RD];
         cfg_hiz <= ctrl_wdata[BIT_HIZ];
         cfg_wfr <= ctrl_wdata[BIT_WFR];
         cfg_cnt <= wr_cnt;
      end
   end

   assign ctrl_rdata = {cfg_wfr, busy, cfg_hiz, cfg_rd, cfg_cnt};

   eeprom3w_tick #(.HALF_CYCLES(HALF_CYCLES)) i_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .tick (tick)
   );

   eeprom3w_shreg #(.DATA_W(DATA_W)) i_shreg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (data_wr && !busy && !accept),
      .load_data(data_wdata),
      .shift    (shift),
      .fill     (fill),
      .data     (data_rdata),
      .msb      (msb)
   );

   eeprom3w_seq #(.CNT_W(CNT_W)) i_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (accept),
      .wr_cnt (wr_cnt),
      .wr_rd  (ctrl_wdata[BIT_RD]),
      .cfg_rd (cfg_rd),
      .cfg_hiz(cfg_hiz),
      .cfg_wfr(cfg_wfr),
      .tick   (tick),
      .msb    (msb),
      .sd_in  (sd_in),
      .run    (run),
      .shift  (shift),
      .fill   (fill),
      .sck    (sck),
      .sd_out (sd_out),
      .sd_oe  (sd_oe),
      .busy   (busy),
      .irq    (irq)
   );
endmodule

// File: rtl/eeprom3w_chk.sv
module eeprom3w_chk #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ctrl_wr,
   input logic              data_wr,
   input logic              busy,
   input logic              irq,
   input logic              sck,
   input logic              sd_oe,
   input logic [CNT_W+3:0]  ctrl_rdata,
   input logic [DATA_W-1:0] data_rdata
);
   // R1: accepted write raises busy next cycle
   a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !busy) |=> busy);

   // R1: configuration frozen while a burst runs
   a_r1_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(ctrl_rdata[CNT_W+3]) && $stable(ctrl_rdata[CNT_W+1:0])));

   // R3: clock idles low
   a_r3_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sck);

   // R3: clock only moves while busy
   a_r3_sck_moves_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sck) |-> busy);

   // R5: line released during read bursts
   a_r5_read_released: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ctrl_rdata[CNT_W]) |-> !sd_oe);

   // R9: interrupt only on busy fall
   a_r9_irq_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $fell(busy));

   // R9: every busy fall gives an interrupt
   a_r9_fall_gives_irq: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> irq);

   // R11: idle data register holds without writes
   a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !ctrl_wr && !data_wr) |=> $stable(data_rdata));
endmodule

bind eeprom3w_engine eeprom3w_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctrl_wr   (ctrl_wr),
   .data_wr   (data_wr),
   .busy      (busy),
   .irq       (irq),
   .sck       (sck),
   .sd_oe     (sd_oe),
   .ctrl_rdata(ctrl_rdata),
   .data_rdata(data_rdata)
);

// File: tb/test_eeprom3w_engine.sv
`timescale 1ns/1ps
module test_eeprom3w_engine;
   localparam int HALF = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctrl_wr = 1'b0;
   logic [7:0] ctrl_wdata = '0;
   logic       data_wr = 1'b0;
   logic [7:0] data_wdata = '0;
   logic [7:0] ctrl_rdata, data_rdata;
   logic       busy, irq, sck, sd_out, sd_oe;
   logic       sd_in = 1'b0;

   always #2 clk = ~clk;

   eeprom3w_engine #(.DATA_W(8), .CNT_W(4), .HALF_CYCLES(HALF)) i_eeprom3w_engine (
      .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
      .data_wr(data_wr), .data_wdata(data_wdata), .ctrl_rdata(ctrl_rdata),
      .data_rdata(data_rdata), .busy(busy), .irq(irq), .sck(sck),
      .sd_out(sd_out), .sd_oe(sd_oe), .sd_in(sd_in)
   );

   int n_cmp = 0;
   int n_bad = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   typedef struct { int sck; int oe; int out; int busy; int irq; } ent_t;
   ent_t q[$];
   int   exp_sck, exp_oe, exp_out, exp_busy, exp_irq;
   logic m_wfr, m_hiz, m_rd;
   logic [3:0] m_cnt;
   logic [7:0] dmodel;
   logic [7:0] rpat = '0;
   bit   waiting, wait_after, sd_last, model_on;

   task automatic push(input int s, input int o, input int d, input int b, input int i);
      ent_t e;
      e.sck = s; e.oe = o; e.out = d; e.busy = b; e.irq = i;
      q.push_back(e);
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
         exp_sck = 0; exp_oe = 0; exp_out = 0; exp_busy = 0; exp_irq = 0;
         m_wfr = 0; m_hiz = 0; m_rd = 0; m_cnt = 0; dmodel = 0;
         waiting = 0; wait_after = 0; sd_last = 0;
      end else begin
         bit acc, rise;
         int c;
         acc = ctrl_wr && (exp_busy == 0);
         if (data_wr && exp_busy == 0 && !acc) dmodel = data_wdata;
         if (acc) begin
            c = (ctrl_wdata[3:0] > 8) ? 8 : int'(ctrl_wdata[3:0]);
            m_wfr = ctrl_wdata[7]; m_hiz = ctrl_wdata[5]; m_rd = ctrl_wdata[4];
            m_cnt = 4'(c);
            for (int b = 0; b < c; b++) begin
               for (int k = 0; k < HALF; k++)
                  push(0, m_rd ? 0 : 1, m_rd ? 2 : int'(dmodel[7-b]), 1, 0);
               for (int k = 0; k < HALF; k++)
                  push(1, (!m_rd && !(m_hiz && b == c-1)) ? 1 : 0,
                       m_rd ? 2 : int'(dmodel[7-b]), 1, 0);
            end
            push(0, 2, 2, 1, 0);
            wait_after = m_hiz && m_wfr;
            push(0, m_hiz ? 0 : 1, m_hiz ? 2 : 0, wait_after ? 1 : 0, wait_after ? 0 : 1);
            if (c > 0) begin
               if (m_rd) dmodel = (dmodel << c) | (rpat >> (8 - c));
               else      dmodel = dmodel << c;
            end
         end
         rise = sd_in && !sd_last;
         sd_last = sd_in;
         if (q.size() > 0) begin
            ent_t e;
            e = q.pop_front();
            exp_sck = e.sck; exp_busy = e.busy; exp_irq = e.irq;
            if (e.oe != 2) exp_oe = e.oe;
            if (e.out != 2) exp_out = e.out;
            if (q.size() == 0 && wait_after) begin
               waiting = 1; wait_after = 0;
            end
         end else if (waiting && rise) begin
            waiting = 0; exp_busy = 0; exp_irq = 1;
         end else begin
            exp_irq = 0;
         end
      end
   end

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (model_on) begin
         chk("R3 sck", 32'(sck), 32'(exp_sck));
         chk("R6 sd_oe", 32'(sd_oe), 32'(exp_oe));
         if (exp_oe == 1) chk("R4 sd_out", 32'(sd_out), 32'(exp_out));
         chk("R8 busy", 32'(busy), 32'(exp_busy));
         chk("R9 irq", 32'(irq), 32'(exp_irq));
         chk("R2 ctrl_rdata", 32'(ctrl_rdata),
             32'({m_wfr, exp_busy[0], m_hiz, m_rd, m_cnt}));
      end
   end

   // EEPROM read responder: next bit after each falling serial clock
   bit resp_en = 0;
   int resp_idx = 0;
   always @(negedge sck) begin
      if (resp_en) begin
         resp_idx++;
         if (resp_idx < 8) sd_in <= rpat[7-resp_idx];
      end
   end

   // ---------------- stimulus ----------------
   task automatic ctrl_write(input logic [7:0] v);
      @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
      @(negedge clk); ctrl_wr = 1'b0;
   endtask

   task automatic data_write(input logic [7:0] v);
      @(negedge clk); data_wr = 1'b1; data_wdata = v;
      @(negedge clk); data_wr = 1'b0;
   endtask

   task automatic wait_idle();
      int n = 0;
      @(negedge clk);
      while ((busy || exp_busy != 0) && n < 2000) begin
         @(negedge clk); n++;
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic start_read(input logic [7:0] pat);
      rpat = pat; resp_idx = 0; sd_in = pat[7]; resp_en = 1;
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 100000) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R12: reset state
      chk("R12 sck", 32'(sck), 0);
      chk("R12 sd_oe", 32'(sd_oe), 0);
      chk("R12 sd_out", 32'(sd_out), 0);
      chk("R12 busy", 32'(busy), 0);
      chk("R12 irq", 32'(irq), 0);
      chk("R12 ctrl_rdata", 32'(ctrl_rdata), 0);
      chk("R12 data_rdata", 32'(data_rdata), 0);
      rst_n = 1'b1;
      @(negedge clk);
      model_on = 1;

      // R4: full write
      data_write(8'hA5);
      ctrl_write(8'h08);
      wait_idle();
      chk("R4 data after 8-bit write", 32'(data_rdata), 32'(dmodel));

      // R4: partial write
      data_write(8'hC3);
      ctrl_write(8'h03);
      wait_idle();
      chk("R4 data after 3-bit write", 32'(data_rdata), 32'(dmodel));
      chk("R4 shifted value", 32'(data_rdata), 32'h18);

      // R5: full read
      data_write(8'h00);
      start_read(8'h3C);
      ctrl_write(8'h18);
      wait_idle();
      resp_en = 0;
      chk("R5 data after 8-bit read", 32'(data_rdata), 32'h3C);

      // R5 + R6: partial read with float
      data_write(8'h81);
      start_read(8'hB0);
      ctrl_write(8'h35);
      wait_idle();
      resp_en = 0; sd_in = 1'b0;
      chk("R5 data after 5-bit read", 32'(data_rdata), 32'h36);
      chk("R6 released after float", 32'(sd_oe), 0);

      // R7: zero count, float clear forces drive low
      ctrl_write(8'h00);
      @(negedge clk);
      chk("R7 zero count drives", 32'(sd_oe), 1);
      chk("R7 zero count value", 32'(sd_out), 0);
      wait_idle();

      // R7: zero count, float set releases
      ctrl_write(8'h20);
      @(negedge clk);
      chk("R7 zero count floats", 32'(sd_oe), 0);
      wait_idle();

      // R6 + R10: write with float and wait-for-ready
      data_write(8'h5A);
      ctrl_write(8'hA4);
      repeat (8 * HALF + 30) @(negedge clk);
      chk("R10 busy held for ready", 32'(busy), 1);
      sd_in = 1'b1;
      repeat (3) @(negedge clk);
      chk("R10 busy released after ready", 32'(busy), 0);
      wait_idle();
      sd_in = 1'b0;
      repeat (2) @(negedge clk);

      // R10: wait-for-ready ignored with float clear
      data_write(8'hF0);
      ctrl_write(8'h82);
      repeat (4 * HALF + 1) @(negedge clk);
      chk("R10 no wait when float clear", 32'(busy), 0);
      chk("R9 pulse at busy fall", 32'(irq), 1);
      wait_idle();

      // R2: count clamp
      data_write(8'h96);
      ctrl_write(8'h0C);
      chk("R2 clamped count", 32'(ctrl_rdata[3:0]), 8);
      wait_idle();
      chk("R2 clamped burst data", 32'(data_rdata), 32'(dmodel));

      // R1 + R11: writes during a burst are ignored
      data_write(8'h6D);
      ctrl_write(8'h08);
      repeat (5) @(negedge clk);
      ctrl_write(8'h13);
      data_write(8'hFF);
      chk("R1 config unchanged by busy write", 32'({ctrl_rdata[7], ctrl_rdata[5:0]}),
          32'(7'h08));
      wait_idle();
      chk("R11 data unaffected by busy write", 32'(data_rdata), 32'h00);
      chk("R1 burst length unchanged", 32'(ctrl_rdata[3:0]), 8);

      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule